// File: doc/BRIEF.md
# Data Memory Access Guard

This block sits between a 32-bit core's load/store stage and a byte-addressed data memory that returns read data in the same cycle. For every request it decides whether the access is legal. An access is illegal if its address is not a multiple of the access size, or if the core runs in user mode and targets the upper half of the 4 GB space. Legal stores are steered onto the memory's byte lanes with per-byte write enables in little-endian order. Legal loads have the addressed byte or half-word pulled from the returned word and widened to 32 bits with sign or zero fill.

An illegal access never reaches memory and never writes a register. On the clock edge that follows it, the block raises a one-cycle exception request. With that request it gives a cause code that tells a faulting load from a faulting store, and the faulting byte address, which stays in a bad-address register until the next fault.

Top module: `mem_access_guard`

## Requirements
- R1: For a legal store, `mem_en` is 1 and `mem_be` depends on `req_size` (00 byte, 01 half-word, 10 or 11 word). A byte store enables only lane `req_addr[1:0]`. A half-word store enables 0011 at offset 0 and 1100 at offset 2. A word store enables 1111. `mem_addr` is `req_addr` with bits 1:0 cleared.
- R2: Store data is replicated across the lanes. A byte store drives its byte onto all four lanes, a half-word store drives its half-word onto both halves, and a word store drives the word unchanged.
- R3: A legal load asserts `ld_wb_en` in the same cycle. `ld_data` takes the byte at lane `req_addr[1:0]` or the half-word at lane pair `req_addr[1]` from `mem_rdata`. It extends that value to 32 bits with its top bit when `req_signed` is 1, and with zeros when it is 0. Word loads pass `mem_rdata` through unchanged.
- R4: A half-word access with `req_addr[0]` set faults. A word access with either of `req_addr[1:0]` set faults. Byte accesses never fault on alignment.
- R5: When `user_mode` is 1, any access with `req_addr[31]` set faults. When `user_mode` is 0, the address range never causes a fault.
- R6: During a faulting request, `mem_en`, `mem_be` and `ld_wb_en` are all zero in that same cycle.
- R7: `exc_req` is 1 for exactly the cycle after each faulting request. Back-to-back faults give one pulse per fault.
- R8: One cycle after a fault, `exc_cause` becomes 4 for a load or 5 for a store. It keeps that value until the next fault.
- R9: One cycle after a fault, `bad_addr` becomes the full byte address of the faulting request. It keeps that value otherwise.
- R10: After reset, `exc_req`, `exc_cause` and `bad_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 00 byte, 01 half-word, 10/11 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| req_signed | input | 1 | Sign-extend narrow loads |
| user_mode | input | 1 | Current mode, 1 user, 0 kernel |
| mem_rdata | input | 32 | Word read from memory |
| mem_en | output | 1 | Memory access strobe |
| mem_be | output | 4 | Per-byte write enables |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Lane-steered store data |
| ld_wb_en | output | 1 | Load result may be written back |
| ld_data | output | 32 | Extracted, extended load result |
| exc_req | output | 1 | One-cycle exception request |
| exc_cause | output | 4 | Cause of last fault |
| bad_addr | output | 32 | Address of last fault |

## Verification
An alignment fault and a privilege fault can come from the same request. This happens when user mode issues a misaligned half-word or word access with bit 31 set. The bench builds such requests directly, and the random stream also produces them by mixing sizes, low offsets and the top address bit. Such a request is judged correct when it gives exactly one exception pulse, with the cause chosen by direction only, the full unaligned address captured, and no strobe or writeback.

// File: rtl/mag_pkg.sv
package mag_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

    localparam logic [3:0] CAUSE_NONE       = 4'd0;
    localparam logic [3:0] CAUSE_LOAD_ADDR  = 4'd4;
    localparam logic [3:0] CAUSE_STORE_ADDR = 4'd5;
endpackage

// File: rtl/mag_check.sv
module mag_check
    import mag_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] off,
    input  logic             addr_msb,
    input  logic             user_mode,
    output logic             misalign,
    output logic             priv_viol
);
    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = off[0];
            default: misalign = |off;
        endcase
        priv_viol = user_mode & addr_msb;
    end
endmodule

// File: rtl/mag_store_lane.sv
module mag_store_lane
    import mag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] lane_data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] IDX = OFF_W'(i);
        always_comb begin
            unique case (acc_size_e'(size))
                SZ_BYTE: begin
                    lane_en[i]          = (off == IDX);
                    lane_data[8*i +: 8] = wdata[7:0];
                end
                SZ_HALF: begin
                    lane_en[i]          = (off[OFF_W-1:1] == IDX[OFF_W-1:1]);
                    lane_data[8*i +: 8] = wdata[8*(i%2) +: 8];
                end
                default: begin
                    lane_en[i]          = 1'b1;
                    lane_data[8*i +: 8] = wdata[8*i +: 8];
                end
            endcase
        end
    end
endmodule

// File: rtl/mag_load_extract.sv
module mag_load_extract
    import mag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic              sign_ext,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ld_data
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    always_comb begin
        byte_sel = rdata[8*off +: 8];
        half_sel = rdata[16*off[OFF_W-1:1] +: 16];
        unique case (acc_size_e'(size))
            SZ_BYTE: ld_data = {{(DATA_W-8){sign_ext & byte_sel[7]}}, byte_sel};
            SZ_HALF: ld_data = {{(DATA_W-16){sign_ext & half_sel[15]}}, half_sel};
            default: ld_data = rdata;
        endcase
    end
endmodule

// File: rtl/mem_access_guard.sv
module mem_access_guard
    import mag_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int CAUSE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_signed,
    input  logic                user_mode,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                mem_en,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                ld_wb_en,
    output logic [DATA_W-1:0]   ld_data,
    output logic                exc_req,
    output logic [CAUSE_W-1:0]  exc_cause,
    output logic [ADDR_W-1:0]   bad_addr
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    typedef struct packed {
        logic               exc;
        logic [CAUSE_W-1:0] cause;
        logic [ADDR_W-1:0]  bad;
    } fault_st_t;

    fault_st_t st_d, st_q;

    logic             misalign, priv_viol, fault;
    logic [LANES-1:0] lane_en;
    logic [OFF_W-1:0] off;

    assign off = req_addr[OFF_W-1:0];

    mag_check #(.OFF_W(OFF_W)) u_check (
        .size      (req_size),
        .off       (off),
        .addr_msb  (req_addr[ADDR_W-1]),
        .user_mode (user_mode),
        .misalign  (misalign),
        .priv_viol (priv_viol)
    );

    mag_store_lane #(.DATA_W(DATA_W)) u_store (
        .size      (req_size),
        .off       (off),
        .wdata     (req_wdata),
        .lane_en   (lane_en),
        .lane_data (mem_wdata)
    );

    mag_load_extract #(.DATA_W(DATA_W)) u_load (
        .size     (req_size),
        .off      (off),
        .sign_ext (req_signed),
        .rdata    (mem_rdata),
        .ld_data  (ld_data)
    );

    always_comb begin
        fault    = req_valid & (misalign | priv_viol);
        mem_en   = req_valid & ~fault;
        mem_be   = (mem_en & req_write) ? lane_en : '0;
        ld_wb_en = mem_en & ~req_write;
        mem_addr = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

        st_d     = st_q;
        st_d.exc = fault;
        if (fault) begin
            st_d.cause = req_write ? CAUSE_W'(CAUSE_STORE_ADDR) : CAUSE_W'(CAUSE_LOAD_ADDR);
            st_d.bad   = req_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign exc_req   = st_q.exc;
    assign exc_cause = st_q.cause;
    assign bad_addr  = st_q.bad;
endmodule

// File: rtl/mag_checker.sv
module mag_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic [31:0] req_addr,
    input logic        user_mode,
    input logic        mem_en,
    input logic [3:0]  mem_be,
    input logic        ld_wb_en,
    input logic        exc_req,
    input logic [3:0]  exc_cause,
    input logic [31:0] bad_addr
);
    logic bad_align, bad_priv;
    assign bad_align = (req_size == 2'b01) ? req_addr[0] :
                       (req_size == 2'b00) ? 1'b0 : (req_addr[1:0] != 2'b00);
    assign bad_priv  = user_mode && req_addr[31];

    assert_be_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && req_write) |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                                   mem_be == 4'b1100 || mem_be == 4'b1111));

    assert_misalign_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_align) |-> !mem_en);

    assert_priv_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bad_priv) |-> !mem_en);

    assert_no_side_effect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |-> (mem_be == 4'b0000 && !ld_wb_en));

    assert_exc_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (bad_align || bad_priv)) |=> exc_req);

    assert_no_spurious_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && (bad_align || bad_priv)) |=> !exc_req);

    assert_cause_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> (exc_cause == 4'd4 || exc_cause == 4'd5));

    assert_badaddr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && (bad_align || bad_priv)) |=> $stable(bad_addr));
endmodule

bind mem_access_guard mag_checker u_mag_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .user_mode (user_mode),
    .mem_en    (mem_en),
    .mem_be    (mem_be),
    .ld_wb_en  (ld_wb_en),
    .exc_req   (exc_req),
    .exc_cause (exc_cause),
    .bad_addr  (bad_addr)
);

// File: tb/sim_mem_access_guard.sv
module sim_mem_access_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0, user_mode = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
    logic        mem_en, ld_wb_en, exc_req;
    logic [3:0]  mem_be, exc_cause;
    logic [31:0] mem_addr, mem_wdata, ld_data, bad_addr;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic        m_exc = 0;
    logic [3:0]  m_cause = 0;
    logic [31:0] m_bad = 0;

    always #5 clk = ~clk;

    mem_access_guard u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_signed(req_signed), .user_mode(user_mode), .mem_rdata(mem_rdata),
        .mem_en(mem_en), .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .ld_wb_en(ld_wb_en), .ld_data(ld_data), .exc_req(exc_req),
        .exc_cause(exc_cause), .bad_addr(bad_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit f_fault(input logic [1:0] sz, input logic [31:0] a, input logic um);
        int unsigned nbytes = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        return ((a % nbytes) != 0) || (um && (a >= 32'h8000_0000));
    endfunction

    function automatic logic [3:0] f_be(input logic [1:0] sz, input logic [31:0] a);
        if (sz == 2'b00) return 4'b0001 << (a & 3);
        if (sz == 2'b01) return (a & 2) ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] f_wd(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'b00) return (d & 32'hFF) * 32'h0101_0101;
        if (sz == 2'b01) return (d & 32'hFFFF) * 32'h0001_0001;
        return d;
    endfunction

    function automatic logic [31:0] f_ld(input logic [1:0] sz, input logic [31:0] a,
                                         input logic sg, input logic [31:0] rd);
        logic [31:0] v;
        if (sz == 2'b00) begin
            v = (rd >> (8 * (a % 4))) & 32'hFF;
            if (sg && v >= 32'h80) v = v | 32'hFFFF_FF00;
        end else if (sz == 2'b01) begin
            v = (rd >> (16 * ((a / 2) % 2))) & 32'hFFFF;
            if (sg && v >= 32'h8000) v = v | 32'hFFFF_0000;
        end else begin
            v = rd;
        end
        return v;
    endfunction

    task automatic step(input logic v, input logic w, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input logic sg, input logic um, input logic [31:0] rd);
        bit flt;
        @(negedge clk);
        chk(exc_req === m_exc, "R7 exc_req", {31'b0, exc_req}, {31'b0, m_exc});
        chk(exc_cause === m_cause, "R8 exc_cause", {28'b0, exc_cause}, {28'b0, m_cause});
        chk(bad_addr === m_bad, "R9 bad_addr", bad_addr, m_bad);
        req_valid = v; req_write = w; req_size = sz; req_addr = a;
        req_wdata = wd; req_signed = sg; user_mode = um; mem_rdata = rd;
        #1;
        flt = v && f_fault(sz, a, um);
        if (flt) begin
            chk(!mem_en && mem_be == 0 && !ld_wb_en, "R6 blocked (R4/R5)",
                {mem_en, ld_wb_en, 26'b0, mem_be}, 32'h0);
        end else if (v && w) begin
            chk(mem_en && mem_be == f_be(sz, a), "R1 mem_be", {27'b0, mem_en, mem_be},
                {27'b0, 1'b1, f_be(sz, a)});
            chk(mem_addr == (a & 32'hFFFF_FFFC), "R1 mem_addr", mem_addr, a & 32'hFFFF_FFFC);
            chk(mem_wdata == f_wd(sz, wd), "R2 mem_wdata", mem_wdata, f_wd(sz, wd));
            chk(!ld_wb_en, "R3 no wb on store", {31'b0, ld_wb_en}, 32'h0);
        end else if (v) begin
            chk(mem_en && ld_wb_en && mem_be == 0, "R3 load strobes",
                {mem_en, ld_wb_en, 26'b0, mem_be}, 32'hC000_0000);
            chk(ld_data == f_ld(sz, a, sg, rd), "R3 ld_data", ld_data, f_ld(sz, a, sg, rd));
        end else begin
            chk(!mem_en && !ld_wb_en && mem_be == 0, "R6 idle", {mem_en, ld_wb_en, 26'b0, mem_be}, 32'h0);
        end
        m_exc = flt;
        if (flt) begin
            m_cause = w ? 4'd5 : 4'd4;
            m_bad   = a;
        end
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        chk(exc_req === 0 && exc_cause === 0 && bad_addr === 0, "R10 reset",
            {exc_req, 27'b0, exc_cause}, 32'h0);
        rst_n = 1'b1;
        // directed: lanes and replication (R1, R2)
        for (int o = 0; o < 4; o++) step(1, 1, 2'b00, 32'h0000_1000 + o, 32'hA5A5_12C3, 0, 0, 0);
        step(1, 1, 2'b01, 32'h0000_2002, 32'h0000_BEEF, 0, 1, 0);
        step(1, 1, 2'b11, 32'h0000_3004, 32'hDEAD_BEEF, 0, 1, 0);
        // directed: loads with extension (R3)
        step(1, 0, 2'b00, 32'h0000_0003, 0, 1, 1, 32'h80FF_7F01);
        step(1, 0, 2'b00, 32'h0000_0003, 0, 0, 1, 32'h80FF_7F01);
        step(1, 0, 2'b01, 32'h0000_0002, 0, 1, 1, 32'h8001_7FFF);
        // alignment faults, back-to-back (R4, R7, R8, R9)
        step(1, 0, 2'b01, 32'h0000_0011, 0, 0, 0, 0);
        step(1, 1, 2'b10, 32'h0000_0022, 32'h1, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0, 0, 0);
        // privilege (R5): kernel allowed, user blocked, both faults at once
        step(1, 1, 2'b10, 32'hFFFF_FFFC, 32'h1234_5678, 0, 0, 0);
        step(1, 0, 2'b10, 32'h8000_0000, 0, 0, 1, 0);
        step(1, 1, 2'b01, 32'h9000_0001, 0, 0, 1, 0);
        step(1, 0, 2'b00, 32'h7FFF_FFFF, 0, 1, 1, 32'hFF00_0000);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a = $urandom;
            if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
            step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, 2'($urandom_range(0, 3)),
                 a, $urandom, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom);
        end
        step(0, 0, 2'b00, 0, 0, 0, 0, 0);
        step(0, 0, 2'b00, 0, 0, 0, 0, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule